// File: doc/BRIEF.md
# Sized Base Address Register with Request Decode

This block is the memory-space base address register of an endpoint, together with the address comparator that decides whether an incoming request targets it. The register is either a single 32-bit register or a 64-bit register made of a low and a high dword. The size of the memory window is a power of two fixed by a parameter. No length register exists. The window size shows only in the low address bits, which are hardwired to zero. Enumeration software learns the size by writing all ones and reading back. It then writes the assigned, size-aligned base. The four lowest bits of the low dword are read-only type bits.

Configuration accesses arrive on a valid/ready request stream. Reads return on a valid/ready response stream holding one entry. A request is taken only when the response slot is empty or is being emptied in the same cycle, so a stalled response stalls further configuration requests. Request addresses arrive on a second valid/ready stream. Each one produces one registered hit flag and in-window byte offset on an output stream. A result that is not taken holds the input stream off. Both output streams keep their data stable while valid is high and ready is low.

Top module: `sized_bar`

## Requirements
- R1: After reset the stored base is zero. The low dword reads back as the type bits alone, which is 0x0000000C for the default 64-bit prefetchable BAR, and the high dword reads 0. Neither output stream is valid.
- R2: After all ones are written to both dwords, the low dword reads with ones in bits [31:SIZE_LOG2], zeros from bit 4 up to SIZE_LOG2-1, and the type bits in [3:0]. For the default 256-byte window this is 0xFFFFFF0C. The high dword of a 64-bit BAR below 4 GB reads 0xFFFFFFFF.
- R3: Bits [3:0] of the low dword ignore writes. Bit 0 is 0 for memory space, bits [2:1] are 2'b10 for a 64-bit BAR or 2'b00 for a 32-bit BAR, and bit 3 is the prefetchable flag.
- R4: A write changes only the bytes whose byte enable is set. Enable bit n covers data bits [8n+7:8n]. Field cfg_req_dw selects the dword: 0 is the low dword and 1 is the high dword.
- R5: A request is a hit when mem_en is high and address bits [63:SIZE_LOG2] equal the stored base bits [63:SIZE_LOG2]. On a hit, dec_out_off equals address bits [SIZE_LOG2-1:0].
- R6: A request whose masked address differs from the base in any compared bit, in either dword, is reported with hit 0 and offset 0.
- R7: When mem_en is low at the moment a request is taken, the result is a miss, even if the address is inside the window.
- R8: A read response appears on the cycle after the read request is taken. While cfg_rsp_valid is high and cfg_rsp_ready is low, cfg_req_ready is low and cfg_rsp_data stays unchanged.
- R9: A decode result appears on the cycle after its address is taken, and results come out in order. While dec_out_valid is high and dec_out_ready is low, the result holds and dec_in_ready is low.
- R10: A decode taken in the same cycle as a base write is compared against the base from before that write. The next decode sees the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_en | input | 1 | Memory decoding enable; a miss is forced when low |
| cfg_req_valid | input | 1 | Configuration request valid |
| cfg_req_ready | output | 1 | Configuration request accepted this cycle when high with valid |
| cfg_req_we | input | 1 | 1 for a write, 0 for a read |
| cfg_req_dw | input | 1 | Dword select: 0 low, 1 high |
| cfg_req_be | input | 4 | Write byte enables |
| cfg_req_wdata | input | 32 | Write data |
| cfg_rsp_valid | output | 1 | Read response valid |
| cfg_rsp_ready | input | 1 | Read response taken by the consumer |
| cfg_rsp_data | output | 32 | Read data |
| dec_in_valid | input | 1 | Request address valid |
| dec_in_ready | output | 1 | Request address accepted when high with valid |
| dec_in_addr | input | ADDR_W | Request byte address |
| dec_out_valid | output | 1 | Decode result valid |
| dec_out_ready | input | 1 | Decode result taken by the consumer |
| dec_out_hit | output | 1 | Address falls inside the programmed window |
| dec_out_off | output | SIZE_LOG2 | Byte offset within the window (0 on a miss) |

## Verification
A base write on the configuration stream and an address taken on the decode stream can land on the same clock edge. The ordering between them then decides which base the comparison uses. The bench drives both streams from parallel tasks on the same cycle. It moves the base so that the address hits the old window but misses the new one. It expects a hit with the old offset for that address, then a miss for a second copy of it and a hit for an address in the new window. The response and result hold rules are checked by stalling each consumer for several cycles and watching ready on the matching input stream.

// File: rtl/bar_pkg.sv
package bar_pkg;

  typedef struct packed {
    logic        we;
    logic        dw;
    logic [3:0]  be;
    logic [31:0] data;
  } cfg_req_t;

  // Bit i set when lo <= i < hi.
  function automatic logic [63:0] span_mask(int lo, int hi);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

  function automatic logic [3:0] type_nibble(bit wide, bit pref);
    return {pref, wide, 1'b0, 1'b0};
  endfunction

endpackage

// File: rtl/bar_cfg_port.sv
module bar_cfg_port
  import bar_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  cfg_req_t    req,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  input  logic [31:0] rd_lo,
  input  logic [31:0] rd_hi,
  output logic        wr_en
);

  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_en     = accept && req.we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req.we) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req.dw ? rd_hi : rd_lo;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r8_req_block: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

endmodule

// File: rtl/bar_regs.sv
module bar_regs
  import bar_pkg::*;
#(
  parameter bit IS_64     = 1'b1,
  parameter int SIZE_LOG2 = 8,
  parameter bit PREFETCH  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_dw,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  output logic [63:0] base,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi
);

  localparam int          BAR_W = IS_64 ? 64 : 32;
  localparam int          LOW_CUT = (SIZE_LOG2 < 4) ? 4 : SIZE_LOG2;
  localparam logic [63:0] WMASK = span_mask(LOW_CUT, BAR_W);
  localparam logic [3:0]  TYPE  = type_nibble(IS_64, PREFETCH);

  logic [63:0] bar_q;

  for (genvar l = 0; l < 8; l++) begin : g_lane
    localparam int DW = l / 4;
    localparam int BL = l % 4;
    always_ff @(posedge clk) begin
      if (!rst_n)
        bar_q[l*8 +: 8] <= '0;
      else if (wr_en && (wr_dw == DW[0]) && wr_be[BL])
        bar_q[l*8 +: 8] <= wr_data[BL*8 +: 8] & WMASK[l*8 +: 8];
    end
  end

  assign base  = bar_q;
  assign rd_lo = {bar_q[31:4], TYPE};
  assign rd_hi = bar_q[63:32];

  a_r4_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_dw && !wr_be[0] |=> $stable(bar_q[7:0]));

  a_r4_hi_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_dw |=> $stable(bar_q[63:32]));

endmodule

// File: rtl/bar_addr_match.sv
module bar_addr_match #(
  parameter int ADDR_W    = 64,
  parameter int SIZE_LOG2 = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mem_en,
  input  logic [63:0]          base,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [ADDR_W-1:0]    in_addr,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_hit,
  output logic [SIZE_LOG2-1:0] out_off
);

  logic accept, hit_c;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign hit_c    = mem_en &&
                    (in_addr[ADDR_W-1:SIZE_LOG2] == base[ADDR_W-1:SIZE_LOG2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_off   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_hit   <= hit_c;
      out_off   <= hit_c ? in_addr[SIZE_LOG2-1:0] : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r7_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mem_en |=> out_valid && !out_hit);

  a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hit) && $stable(out_off));

  a_r9_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

endmodule

// File: rtl/sized_bar.sv
module sized_bar
  import bar_pkg::*;
#(
  parameter bit IS_64     = 1'b1,
  parameter int SIZE_LOG2 = 8,
  parameter bit PREFETCH  = 1'b1,
  parameter int ADDR_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mem_en,
  input  logic                 cfg_req_valid,
  output logic                 cfg_req_ready,
  input  logic                 cfg_req_we,
  input  logic                 cfg_req_dw,
  input  logic [3:0]           cfg_req_be,
  input  logic [31:0]          cfg_req_wdata,
  output logic                 cfg_rsp_valid,
  input  logic                 cfg_rsp_ready,
  output logic [31:0]          cfg_rsp_data,
  input  logic                 dec_in_valid,
  output logic                 dec_in_ready,
  input  logic [ADDR_W-1:0]    dec_in_addr,
  output logic                 dec_out_valid,
  input  logic                 dec_out_ready,
  output logic                 dec_out_hit,
  output logic [SIZE_LOG2-1:0] dec_out_off
);

  cfg_req_t    req;
  logic        wr_en;
  logic [63:0] base;
  logic [31:0] rd_lo, rd_hi;

  assign req = '{we: cfg_req_we, dw: cfg_req_dw, be: cfg_req_be, data: cfg_req_wdata};

  bar_cfg_port u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cfg_req_valid),
    .req_ready (cfg_req_ready),
    .req       (req),
    .rsp_valid (cfg_rsp_valid),
    .rsp_ready (cfg_rsp_ready),
    .rsp_data  (cfg_rsp_data),
    .rd_lo     (rd_lo),
    .rd_hi     (rd_hi),
    .wr_en     (wr_en)
  );

  bar_regs #(.IS_64(IS_64), .SIZE_LOG2(SIZE_LOG2), .PREFETCH(PREFETCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_dw   (req.dw),
    .wr_be   (req.be),
    .wr_data (req.data),
    .base    (base),
    .rd_lo   (rd_lo),
    .rd_hi   (rd_hi)
  );

  bar_addr_match #(.ADDR_W(ADDR_W), .SIZE_LOG2(SIZE_LOG2)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_en    (mem_en),
    .base      (base),
    .in_valid  (dec_in_valid),
    .in_ready  (dec_in_ready),
    .in_addr   (dec_in_addr),
    .out_valid (dec_out_valid),
    .out_ready (dec_out_ready),
    .out_hit   (dec_out_hit),
    .out_off   (dec_out_off)
  );

endmodule

// File: tb/sim_sized_bar.sv
module sim_sized_bar;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_en = 1'b1;
  logic        cfg_req_valid = 1'b0, cfg_req_we = 1'b0, cfg_req_dw = 1'b0;
  logic [3:0]  cfg_req_be = '0;
  logic [31:0] cfg_req_wdata = '0;
  logic        cfg_req_ready, cfg_rsp_valid;
  logic        cfg_rsp_ready = 1'b1;
  logic [31:0] cfg_rsp_data;
  logic        dec_in_valid = 1'b0, dec_in_ready, dec_out_valid, dec_out_hit;
  logic [63:0] dec_in_addr = '0;
  logic        dec_out_ready = 1'b1;
  logic [7:0]  dec_out_off;

  int n_run = 0, n_fail = 0;

  logic [31:0] rd_q[$];
  string       rd_tag[$];
  logic [8:0]  dc_q[$];
  string       dc_tag[$];

  always #10 clk = ~clk;

  sized_bar u0 (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(bit dw, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_we = 1'b1; cfg_req_dw = dw;
    cfg_req_be = be; cfg_req_wdata = d;
    while (!cfg_req_ready) @(negedge clk);
    @(negedge clk);
    cfg_req_valid = 1'b0;
  endtask

  task automatic cfg_rd(bit dw, logic [31:0] exp, string tag);
    rd_q.push_back(exp); rd_tag.push_back(tag);
    @(negedge clk);
    cfg_req_valid = 1'b1; cfg_req_we = 1'b0; cfg_req_dw = dw; cfg_req_be = '0;
    while (!cfg_req_ready) @(negedge clk);
    @(negedge clk);
    cfg_req_valid = 1'b0;
  endtask

  task automatic dec_send(logic [63:0] a, bit hit, logic [7:0] off, string tag);
    dc_q.push_back({hit, off}); dc_tag.push_back(tag);
    @(negedge clk);
    dec_in_valid = 1'b1; dec_in_addr = a;
    while (!dec_in_ready) @(negedge clk);
    @(negedge clk);
    dec_in_valid = 1'b0;
  endtask

  task automatic set_rsp_ready(bit v);
    @(posedge clk); #2 cfg_rsp_ready = v;
  endtask

  task automatic set_out_ready(bit v);
    @(posedge clk); #2 dec_out_ready = v;
  endtask

  // Monitor: pops the scoreboard on every completed transfer.
  always @(negedge clk) begin
    if (rst_n && cfg_rsp_valid && cfg_rsp_ready) begin
      if (rd_q.size() == 0) chk(1'b0, "R8 unexpected response", cfg_rsp_data, 0);
      else chk(cfg_rsp_data == rd_q[0], rd_tag[0], cfg_rsp_data, rd_q[0]);
      if (rd_q.size() != 0) begin void'(rd_q.pop_front()); void'(rd_tag.pop_front()); end
    end
    if (rst_n && dec_out_valid && dec_out_ready) begin
      if (dc_q.size() == 0) chk(1'b0, "R9 unexpected result", {dec_out_hit, dec_out_off}, 0);
      else chk({dec_out_hit, dec_out_off} == dc_q[0], dc_tag[0],
               {dec_out_hit, dec_out_off}, dc_q[0]);
      if (dc_q.size() != 0) begin void'(dc_q.pop_front()); void'(dc_tag.pop_front()); end
    end
  end

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cfg_rsp_valid && !dec_out_valid, "R1 streams idle", {cfg_rsp_valid, dec_out_valid}, 0);
    cfg_rd(1'b0, 32'h0000000C, "R1 low after reset");
    cfg_rd(1'b1, 32'h00000000, "R1 high after reset");

    // Size probe.
    cfg_wr(1'b0, 4'hF, 32'hFFFFFFFF);
    cfg_wr(1'b1, 4'hF, 32'hFFFFFFFF);
    cfg_rd(1'b0, 32'hFFFFFF0C, "R2 probe low");
    cfg_rd(1'b1, 32'hFFFFFFFF, "R2 probe high");

    // Type bits are read-only.
    cfg_wr(1'b0, 4'hF, 32'h00000000);
    cfg_rd(1'b0, 32'h0000000C, "R3 type bits kept");

    // Program base 0x0000ABCD_12345600.
    cfg_wr(1'b0, 4'hF, 32'h12345600);
    cfg_wr(1'b1, 4'hF, 32'h0000ABCD);
    cfg_wr(1'b0, 4'b0100, 32'hFFFFFFFF);
    cfg_rd(1'b0, 32'h12FF560C, "R4 single byte lane");
    cfg_wr(1'b1, 4'b0001, 32'h00000011);
    cfg_rd(1'b1, 32'h0000AB11, "R4 high dword lane 0");
    cfg_wr(1'b0, 4'hF, 32'h12345600);
    cfg_wr(1'b1, 4'hF, 32'h0000ABCD);

    dec_send(64'h0000ABCD_123456A7, 1'b1, 8'hA7, "R5 hit mid");
    dec_send(64'h0000ABCD_12345600, 1'b1, 8'h00, "R5 hit first byte");
    dec_send(64'h0000ABCD_123456FF, 1'b1, 8'hFF, "R5 hit last byte");
    dec_send(64'h0000ABCD_12345700, 1'b0, 8'h00, "R6 miss above window");
    dec_send(64'h0000ABCD_123455FF, 1'b0, 8'h00, "R6 miss below window");
    dec_send(64'h0001ABCD_12345610, 1'b0, 8'h00, "R6 miss upper dword");

    mem_en = 1'b0;
    dec_send(64'h0000ABCD_12345642, 1'b0, 8'h00, "R7 disabled miss");
    mem_en = 1'b1;

    // Response back-pressure.
    set_rsp_ready(1'b0);
    cfg_rd(1'b1, 32'h0000ABCD, "R8 stalled read");
    repeat (2) @(negedge clk);
    chk(cfg_rsp_valid && !cfg_req_ready, "R8 stall blocks requests",
        {cfg_rsp_valid, cfg_req_ready}, 2'b10);
    chk(cfg_rsp_data == 32'h0000ABCD, "R8 data held", cfg_rsp_data, 32'h0000ABCD);
    set_rsp_ready(1'b1);

    // Result back-pressure.
    set_out_ready(1'b0);
    dec_send(64'h0000ABCD_12345633, 1'b1, 8'h33, "R9 stalled result");
    repeat (3) @(negedge clk);
    chk(dec_out_valid && !dec_in_ready, "R9 stall blocks input",
        {dec_out_valid, dec_in_ready}, 2'b10);
    chk({dec_out_hit, dec_out_off} == 9'h133, "R9 result held",
        {dec_out_hit, dec_out_off}, 9'h133);
    set_out_ready(1'b1);

    // Base write and decode taken on the same edge.
    fork
      cfg_wr(1'b0, 4'hF, 32'h12345700);
      dec_send(64'h0000ABCD_123456A7, 1'b1, 8'hA7, "R10 old base used");
    join
    dec_send(64'h0000ABCD_123456A7, 1'b0, 8'h00, "R10 new base miss");
    dec_send(64'h0000ABCD_12345733, 1'b1, 8'h33, "R10 new base hit");

    repeat (4) @(negedge clk);
    chk(rd_q.size() == 0, "R8 responses drained", rd_q.size(), 0);
    chk(dc_q.size() == 0, "R9 results drained", dc_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule